// File: doc/BRIEF.md
# Always-On Sleep and Wake Power Controller

This block sits in the always-on slow clock domain and decides when the main power domain is switched off and back on. Software programs it through a small word-addressed register port: a control register carrying a sleep request bit and a two-bit sleep mode, a wake-source enable mask, a read-only view of the wake pin levels, a read-only state code, and two general scratch registers. Software uses the scratch registers to keep values such as a resume address, because they are the only software-visible storage that outlives the main domain.

Software requests sleep by writing the control register with the request bit set and the mode field at the deep-sleep value. The controller then drops the main power enable, holds a short shut-down window and settles in the sleep state. A rising edge on any wake input whose enable bit is set starts the wake sequence. The controller raises the power enable again, flags the wake for a fixed window, clears the request bit and returns to the run state. A request with any other mode value is discarded, and the main domain stays on.

Top module: `aon_power_ctl`

## Requirements
- R1: After reset the main power enable is 1, the wake flag is 0, the state code at offset 0x04 reads 0, and the control, enable and scratch registers read 0.
- R2: The scratch registers at offsets 0x18 and 0x1C hold all 32 written bits. Their values are unchanged by a full sleep and wake cycle.
- R3: The wake enable register at offset 0x08 stores bits [NUM_WAKE-1:0] of the written word and reads 0 in all higher bits. Bit 0 enables wake input 0, the on-key.
- R4: The pin status register at offset 0x14 reads the wake input levels in bits [NUM_WAKE-1:0]. A change at the pins becomes visible after two clock edges. Writes to this register are ignored.
- R5: The control register at offset 0x00 has the sleep request in bit 0 and the sleep mode in bits [2:1]. Mode value 1 means deep sleep. In the run state, a write with bit 0 set and mode 1 moves the state to shut-down (code 1) on the next edge, and the power enable goes to 0.
- R6: A sleep request written with any mode other than 1 leaves the state at run (code 0). Bit 0 reads 0 one edge later, and the mode field keeps its written value.
- R7: The shut-down state lasts OFF_DLY cycles and is followed by the sleep state (code 2). The power enable stays 0 in both states.
- R8: In the sleep state, a rising edge on an enabled wake input enters the wake state (code 3) on the third clock edge after the pin change. On entry the power enable returns to 1, the wake flag goes to 1 and the request bit is cleared.
- R9: Rising edges on wake inputs whose enable bit is 0 do not leave the sleep state.
- R10: The wake state lasts ON_DLY cycles and then returns to run. The wake flag is 0 again in run.
- R11: Writes to the state code at 0x04 are ignored. Writes to the control register outside the run state are ignored. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| wake_in | input | NUM_WAKE | Asynchronous wake pins, bit 0 is the on-key |
| main_pwr_en | output | 1 | Power enable for the main domain |
| wake_req | output | 1 | High while the wake sequence runs |

## Verification
The register behaviour is tried with a table of writes and reads. The table uses all-ones and mixed bit patterns, so that masked bits, ignored writes and unmapped offsets each show up as a distinct wrong value. The sleep path is tried twice: once with the deep-sleep mode, which must shut down, and once with a different mode, which must not. This separates mode qualification from the request bit itself.

The wake path is tried two ways. An edge on a disabled pin must leave the block asleep. An edge on the enabled on-key pin is then checked against its exact arrival edge, which catches both a missing synchronizer stage and a missing edge detector. The scratch values are read back after the round trip.

// File: rtl/aon_power_ctl.sv
module aon_power_ctl #(
  parameter int NUM_WAKE = 4,
  parameter int OFF_DLY  = 4,
  parameter int ON_DLY   = 4,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_WAKE-1:0] wake_in,
  output logic                main_pwr_en,
  output logic                wake_req
);

  localparam int MAX_DLY = (OFF_DLY > ON_DLY) ? OFF_DLY : ON_DLY;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_WKEN  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_PINS  = ADDR_W'(5'h14);
  localparam logic [ADDR_W-1:0] A_KEEP0 = ADDR_W'(5'h18);
  localparam logic [ADDR_W-1:0] A_KEEP1 = ADDR_W'(5'h1C);
  localparam logic [1:0] MODE_DEEP = 2'd1;

  typedef enum logic [1:0] {RUN = 2'd0, SHUTDOWN = 2'd1, ASLEEP = 2'd2, WAKING = 2'd3} pstate_t;

  pstate_t             state;
  logic [CNT_W-1:0]    cnt;
  logic                force_bit;
  logic [1:0]          mode;
  logic [NUM_WAKE-1:0] wk_en;
  logic [31:0]         keep0, keep1;
  logic [NUM_WAKE-1:0] sync1, sync2, sync3;
  logic [NUM_WAKE-1:0] wk_rise;
  logic                wake_hit;

  assign wk_rise     = sync2 & ~sync3;
  assign wake_hit    = |(wk_rise & wk_en);
  assign main_pwr_en = (state == RUN) || (state == WAKING);
  assign wake_req    = (state == WAKING);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= wake_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RUN;
      cnt   <= '0;
    end else begin
      case (state)
        RUN: begin
          cnt <= '0;
          if (force_bit && mode == MODE_DEEP) state <= SHUTDOWN;
        end
        SHUTDOWN: begin
          if (cnt == CNT_W'(OFF_DLY - 1)) begin
            state <= ASLEEP;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ASLEEP: begin
          cnt <= '0;
          if (wake_hit) state <= WAKING;
        end
        default: begin
          if (cnt == CNT_W'(ON_DLY - 1)) begin
            state <= RUN;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_bit <= 1'b0;
      mode      <= 2'd0;
    end else if (state == ASLEEP && wake_hit) begin
      force_bit <= 1'b0;
    end else if (state == RUN && force_bit) begin
      if (mode != MODE_DEEP) force_bit <= 1'b0;
    end else if (state == RUN && reg_we && reg_addr == A_CTRL) begin
      force_bit <= reg_wdata[0];
      mode      <= reg_wdata[2:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_en <= '0;
      keep0 <= '0;
      keep1 <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_WKEN)  wk_en <= reg_wdata[NUM_WAKE-1:0];
      if (reg_addr == A_KEEP0) keep0 <= reg_wdata;
      if (reg_addr == A_KEEP1) keep1 <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = {29'd0, mode, force_bit};
      A_STATE: reg_rdata = {30'd0, state};
      A_WKEN:  reg_rdata = {{(32-NUM_WAKE){1'b0}}, wk_en};
      A_PINS:  reg_rdata = {{(32-NUM_WAKE){1'b0}}, sync2};
      A_KEEP0: reg_rdata = keep0;
      A_KEEP1: reg_rdata = keep1;
      default: reg_rdata = '0;
    endcase
  end

  p_sleep_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN && force_bit && mode == MODE_DEEP) |=> (state == SHUTDOWN && !main_pwr_en));

  p_bad_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN && force_bit && mode != MODE_DEEP) |=> (state == RUN && !force_bit));

  p_power_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SHUTDOWN) |=> (state == SHUTDOWN || state == ASLEEP) && !main_pwr_en);

  p_wake_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ASLEEP && wake_hit) |=> (state == WAKING && wake_req && !force_bit));

  p_no_wake_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ASLEEP && !wake_hit) |=> (state == ASLEEP));

  p_wake_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAKING) |=> (state == WAKING || (state == RUN && !wake_req)));

endmodule

// File: tb/aon_power_ctl_tb.sv
module aon_power_ctl_tb;
  localparam int NW  = 4;
  localparam int OFF = 4;
  localparam int ON  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NW-1:0] wake_in = '0;
  logic        main_pwr_en, wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  aon_power_ctl #(.NUM_WAKE(NW), .OFF_DLY(OFF), .ON_DLY(ON), .ADDR_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_in(wake_in),
    .main_pwr_en(main_pwr_en), .wake_req(wake_req));

  // {write, offset, data, expected read after the step}
  localparam logic [69:0] VEC [12] = '{
    {1'b1, 5'h18, 32'hDEADBEEF, 32'hDEADBEEF},
    {1'b1, 5'h1C, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {1'b1, 5'h1C, 32'h12345678, 32'h12345678},
    {1'b1, 5'h08, 32'hFFFFFFFF, 32'h0000000F},
    {1'b1, 5'h08, 32'h000000A5, 32'h00000005},
    {1'b1, 5'h08, 32'h00000001, 32'h00000001},
    {1'b1, 5'h14, 32'hFFFFFFFF, 32'h00000000},
    {1'b1, 5'h04, 32'h00000003, 32'h00000000},
    {1'b1, 5'h10, 32'hFFFFFFFF, 32'h00000000},
    {1'b0, 5'h18, 32'h0,        32'hDEADBEEF},
    {1'b1, 5'h00, 32'h00000004, 32'h00000004},
    {1'b1, 5'h00, 32'h00000000, 32'h00000000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pwr_en", {31'd0, main_pwr_en}, 32'd1);
    check("R1 wake_req", {31'd0, wake_req}, 32'd0);
    rd(5'h04, v); check("R1 state", v, 32'd0);
    rd(5'h00, v); check("R1 ctrl", v, 32'd0);
    rd(5'h08, v); check("R1 wken", v, 32'd0);
    rd(5'h18, v); check("R1 keep0", v, 32'd0);
    rd(5'h1C, v); check("R1 keep1", v, 32'd0);

    // R2 R3 R4 R6 R11 register table
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][69]) wr(VEC[i][68:64], VEC[i][63:32]);
      else @(negedge clk);
      rd(VEC[i][68:64], v);
      check($sformatf("R2/R3/R4/R11 table step %0d", i), v, VEC[i][31:0]);
    end

    // R4 pin status with two-edge latency
    @(negedge clk);
    reg_addr = 5'h14;
    wake_in = 4'b1010;
    @(negedge clk); rd(5'h14, v); check("R4 pins after one edge", v, 32'd0);
    @(negedge clk); rd(5'h14, v); check("R4 pins after two edges", v, 32'hA);
    wake_in = 4'b0000;
    repeat (3) @(negedge clk);

    // R6 request with shallow mode is discarded
    wr(5'h00, 32'h5);
    @(negedge clk);
    rd(5'h04, v); check("R6 state stays run", v, 32'd0);
    rd(5'h00, v); check("R6 request cleared mode kept", v, 32'h4);
    check("R6 pwr_en", {31'd0, main_pwr_en}, 32'd1);

    // R5 deep sleep request (on-key enabled only, from table)
    wr(5'h00, 32'h3);
    rd(5'h04, v); check("R5 still run before edge", v, 32'd0);
    @(negedge clk);
    rd(5'h04, v); check("R5 shutdown", v, 32'd1);
    check("R5 pwr_en low", {31'd0, main_pwr_en}, 32'd0);
    // R11 control write ignored outside run
    wr(5'h00, 32'h4);
    rd(5'h00, v); check("R11 ctrl write ignored", v, 32'h3);
    // R7 shutdown lasts OFF cycles (two already elapsed in wr)
    repeat (OFF - 3) @(negedge clk);
    rd(5'h04, v); check("R7 last shutdown cycle", v, 32'd1);
    @(negedge clk);
    rd(5'h04, v); check("R7 asleep", v, 32'd2);
    check("R7 pwr_en low asleep", {31'd0, main_pwr_en}, 32'd0);

    // R9 disabled pin does not wake
    wake_in = 4'b0010;
    repeat (8) @(negedge clk);
    rd(5'h04, v); check("R9 still asleep", v, 32'd2);
    check("R9 pwr_en", {31'd0, main_pwr_en}, 32'd0);
    wake_in = 4'b0000;
    repeat (3) @(negedge clk);

    // R8 on-key edge wakes on third edge
    wake_in = 4'b0001;
    @(negedge clk); @(negedge clk);
    rd(5'h04, v); check("R8 asleep after two edges", v, 32'd2);
    @(negedge clk);
    rd(5'h04, v); check("R8 waking", v, 32'd3);
    check("R8 pwr_en", {31'd0, main_pwr_en}, 32'd1);
    check("R8 wake_req", {31'd0, wake_req}, 32'd1);
    rd(5'h00, v); check("R8 request cleared", v, 32'h2);

    // R10 wake lasts ON cycles
    repeat (ON - 1) @(negedge clk);
    rd(5'h04, v); check("R10 last waking cycle", v, 32'd3);
    @(negedge clk);
    rd(5'h04, v); check("R10 back to run", v, 32'd0);
    check("R10 wake_req low", {31'd0, wake_req}, 32'd0);
    wake_in = 4'b0000;

    // R2 scratch survives
    rd(5'h18, v); check("R2 keep0 after sleep", v, 32'hDEADBEEF);
    rd(5'h1C, v); check("R2 keep1 after sleep", v, 32'h12345678);

    finish_run();
  end
endmodule